// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a 32-bit-wide asynchronous static RAM array made of four byte-wide devices. The devices share the address lines and the data bus. The host issues one request at a time over a valid/ready handshake. A request carries a read/write flag, a 19-bit word address, a 4-bit byte-enable mask and write data. The controller drives one chip enable, one output enable and four per-lane write enables. It controls the shared data bus as a pad-level tri-state through an output value, an output-enable flag and an input value.

Every wait phase is counted in clock cycles. The counts come from picosecond timing parameters and the clock period: address setup, write pulse, data-to-end-of-write, write recovery and read access. A write runs through setup, pulse and recovery phases. A read starts with one cycle in which the bus is released, then keeps output enable low for the access time. It captures the returned word on the edge that ends the access and reports it with a one-cycle response pulse.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it: chip enable, output enable and all four write enables are high (inactive), data drive is off, ready is 1 and response valid is 0.
- R2: A request is accepted on an edge where valid and ready are both 1. Ready stays 0 until the access completes. A write frees the controller after N_AS+N_WP+N_WR cycles. A read frees it after 1+N_RD cycles.
- R3: During a write, each lane whose byte-enable bit is 1 (bit k controls data bits 8k+7..8k) holds its write enable low for exactly N_WP consecutive cycles. Lanes whose bit is 0 keep their write enable high. Output enable stays high for the whole write.
- R4: A write enable falls only after N_AS cycles with chip enable low and the address driven. Address and write data are held stable, and data drive is on, for as long as any write enable is low.
- R5: During a read, output enable is low for exactly N_RD consecutive cycles with chip enable low and every write enable high. Output enable and a write enable are never low together.
- R6: Data drive is off on the cycle before output enable falls and on every cycle output enable is low.
- R7: The word on the data input at the clock edge that ends the access is returned. Response valid is 1 for exactly one cycle, the cycle after output enable rises, with that word on the response data.
- R8: Each phase count is ceil(time_ps / CLK_PERIOD_PS), and at least 1. N_WP uses the larger of the write-pulse and data-to-end-of-write times. With the defaults (4000 ps clock; 0, 17000, 13000, 8000 and 25000 ps), N_AS=1, N_WP=5, N_WR=2 and N_RD=7.
- R9: Whenever the controller is idle (ready is 1), chip enable is high (standby) and data drive is off.
- R10: A read returns, for each lane, the byte written by the most recent write that enabled that lane. A write with a zero mask changes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_be_i | input | 4 | Byte-lane enable mask for writes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | 32 | Read data |
| sram_addr_o | output | 19 | Address to the array |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 4 | Per-lane write enables, active low |
| sram_dq_o | output | 32 | Data driven toward the array |
| sram_dq_oe_o | output | 1 | Data pad drive enable |
| sram_dq_i | input | 32 | Data returned by the array |

## Verification
The assertions assume that the host only raises valid with stable request fields. They also assume that the array model drives the data input only while output enable is low and no write enable is low. The bench respects both assumptions. It issues a request only on a cycle where ready is seen high, and drops valid one cycle later. Its array model returns a fixed filler value whenever the read conditions are not met. The bench sweeps all sixteen byte masks over sixteen addresses and reads back after every write, so the merge and the zero-mask case are covered without dependence on order.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV,
    ST_RTURN,
    ST_RACCESS
  } state_e;

  function automatic int unsigned cycles_for(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe #(
  parameter int unsigned LANES = 4
) (
  input  logic             pulse_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] we_n_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_n_o[g] = ~(pulse_i & be_i[g]);
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_AS_PS       = 0,
  parameter int unsigned T_WP_PS       = 17000,
  parameter int unsigned T_DW_PS       = 13000,
  parameter int unsigned T_WR_PS       = 8000,
  parameter int unsigned T_RD_PS       = 25000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic                sram_ce_n_o,
  output logic                sram_oe_n_o,
  output logic [DATA_W/8-1:0] sram_we_n_o,
  output logic [DATA_W-1:0]   sram_dq_o,
  output logic                sram_dq_oe_o,
  input  logic [DATA_W-1:0]   sram_dq_i
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned T_WP_EFF = (T_WP_PS > T_DW_PS) ? T_WP_PS : T_DW_PS;
  localparam int unsigned N_AS     = cycles_for(T_AS_PS,  CLK_PERIOD_PS);
  localparam int unsigned N_WP     = cycles_for(T_WP_EFF, CLK_PERIOD_PS);
  localparam int unsigned N_WR     = cycles_for(T_WR_PS,  CLK_PERIOD_PS);
  localparam int unsigned N_RD     = cycles_for(T_RD_PS,  CLK_PERIOD_PS);
  localparam int unsigned MAX_A    = (N_AS > N_WP) ? N_AS : N_WP;
  localparam int unsigned MAX_B    = (N_WR > N_RD) ? N_WR : N_RD;
  localparam int unsigned MAX_N    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W    = $clog2(MAX_N + 1);

  state_e              state_q, state_d;
  logic                cnt_load;
  logic [CNT_W-1:0]    cnt_val;
  logic                cnt_done;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    be_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                accept;
  logic                capture;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign capture = (state_q == ST_RACCESS) && cnt_done;

  sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .done_o     (cnt_done)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cnt_load = 1'b1;
        if (req_write_i) begin
          state_d = ST_WSETUP;
          cnt_val = CNT_W'(N_AS - 1);
        end else begin
          state_d = ST_RTURN;
        end
      end
      ST_WSETUP: if (cnt_done) begin
        state_d  = ST_WPULSE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(N_WP - 1);
      end
      ST_WPULSE: if (cnt_done) begin
        state_d  = ST_WRECOV;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(N_WR - 1);
      end
      ST_WRECOV: if (cnt_done) state_d = ST_IDLE;
      ST_RTURN: if (cnt_done) begin
        state_d  = ST_RACCESS;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(N_RD - 1);
      end
      ST_RACCESS: if (cnt_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      be_q        <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= capture;
      if (accept) begin
        addr_q  <= req_addr_i;
        be_q    <= req_write_i ? req_be_i : '0;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= sram_dq_i;
    end
  end

  sram_lane_strobe #(.LANES(LANES)) u_strobe (
    .pulse_i (state_q == ST_WPULSE),
    .be_i    (be_q),
    .we_n_o  (sram_we_n_o)
  );

  // CE stays low through recovery so every WE rise happens under a selected chip
  assign sram_ce_n_o  = (state_q == ST_IDLE);
  assign sram_oe_n_o  = (state_q != ST_RACCESS);
  assign sram_dq_oe_o = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                        (state_q == ST_WRECOV);
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;

  assert_we_under_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_n_o != '1) |-> (!sram_ce_n_o && sram_dq_oe_o));

  assert_oe_we_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_n_o && (sram_we_n_o != '1)));

  assert_write_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sram_we_n_o != '1) && $past(sram_we_n_o != '1)) |->
      ($stable(sram_addr_o) && $stable(sram_dq_o)));

  assert_bus_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_n_o) |-> (!sram_dq_oe_o && !$past(sram_dq_oe_o)));

  assert_no_drive_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> !sram_dq_oe_o);

  assert_rsp_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (sram_oe_n_o && !$past(sram_oe_n_o)));

  assert_idle_standby_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_n_o && !sram_dq_oe_o && sram_oe_n_o));

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int unsigned CLK_PS = 4000;
  localparam int unsigned TAS = 0, TWP = 17000, TDW = 13000, TWR = 8000, TRD = 25000;

  function automatic int unsigned ncyc(int unsigned t);
    int unsigned n;
    n = (t + CLK_PS - 1) / CLK_PS;
    return (n == 0) ? 1 : n;
  endfunction

  localparam int unsigned E_AS = ncyc(TAS);
  localparam int unsigned E_WP = ncyc((TWP > TDW) ? TWP : TDW);
  localparam int unsigned E_WR = ncyc(TWR);
  localparam int unsigned E_RD = ncyc(TRD);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, ce_n, oe_n, dq_oe;
  logic [31:0] rsp_rdata, dq_o, dq_i;
  logic [18:0] sram_addr;
  logic [3:0]  we_n;

  logic [31:0] mem [16];
  logic [31:0] expv [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  sram_ctrl #(
    .CLK_PERIOD_PS(CLK_PS), .T_AS_PS(TAS), .T_WP_PS(TWP),
    .T_DW_PS(TDW), .T_WR_PS(TWR), .T_RD_PS(TRD)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(sram_addr), .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n),
    .sram_we_n_o(we_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // array model: reads need CE, OE low and all WE high
  assign dq_i = (!ce_n && !oe_n && we_n == 4'hF) ? mem[sram_addr[3:0]] : 32'hDEAD_BEEF;

  always @(negedge clk) begin
    if (!ce_n && dq_oe)
      for (int l = 0; l < 4; l++)
        if (!we_n[l]) mem[sram_addr[3:0]][8*l +: 8] <= dq_o[8*l +: 8];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  task automatic do_write(input int a, input logic [3:0] be, input logic [31:0] d);
    int k, first_we, oe_lo;
    int we_lo[4];
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'(a); req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; first_we = 0; oe_lo = 0;
    for (int l = 0; l < 4; l++) we_lo[l] = 0;
    while (!req_ready && k < 100) begin
      for (int l = 0; l < 4; l++) if (!we_n[l]) we_lo[l]++;
      if (we_n != 4'hF && first_we == 0) first_we = k;
      if (!oe_n) oe_lo++;
      k++;
      @(negedge clk);
    end
    check(k == int'(E_AS + E_WP + E_WR + 1), "R2 R8 write busy cycles", k, E_AS + E_WP + E_WR + 1);
    for (int l = 0; l < 4; l++)
      check(we_lo[l] == (be[l] ? int'(E_WP) : 0), "R3 lane write pulse", we_lo[l],
            be[l] ? E_WP : 0);
    check(oe_lo == 0, "R3 oe during write", oe_lo, 0);
    if (be != 0) check(first_we == int'(E_AS + 1), "R4 address setup", first_we, E_AS + 1);
    check(ce_n && !dq_oe, "R9 standby after write", {ce_n, dq_oe}, 2'b10);
    for (int l = 0; l < 4; l++) if (be[l]) expv[a][8*l +: 8] = d[8*l +: 8];
  endtask

  task automatic do_read(input int a);
    int k, first_oe, oe_lo, we_lo, drv;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'(a); req_be = 4'hF; req_wdata = '1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; first_oe = 0; oe_lo = 0; we_lo = 0; drv = 0;
    while (!rsp_valid && k < 100) begin
      if (!oe_n) begin
        oe_lo++;
        if (first_oe == 0) first_oe = k;
        if (ce_n) drv++;
      end
      if (we_n != 4'hF) we_lo++;
      if (dq_oe) drv++;
      k++;
      @(negedge clk);
    end
    check(k == int'(E_RD + 2), "R2 R7 read latency", k, E_RD + 2);
    check(oe_lo == int'(E_RD), "R5 R8 oe width", oe_lo, E_RD);
    check(we_lo == 0, "R5 no write strobe", we_lo, 0);
    check(first_oe == 2, "R6 turnaround before oe", first_oe, 2);
    check(drv == 0, "R6 bus released in read", drv, 0);
    check(rsp_rdata == expv[a], "R7 R10 read data", rsp_rdata, expv[a]);
    check(req_ready && ce_n, "R9 idle at response", {req_ready, ce_n}, 2'b11);
    @(negedge clk);
    check(!rsp_valid, "R7 single response pulse", rsp_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'hA5A5_A5A5 ^ (32'(i) * 32'h0101_0101);
      expv[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n == 4'hF && !dq_oe && req_ready && !rsp_valid,
          "R1 reset state", {ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid}, 9'b111111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n == 4'hF && !dq_oe && req_ready && !rsp_valid,
          "R1 after reset", {ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid}, 9'b111111010);
    check(E_AS == 1 && E_WP == 5 && E_WR == 2 && E_RD == 7, "R8 default counts",
          {E_AS[7:0], E_WP[7:0], E_WR[7:0], E_RD[7:0]}, 32'h01050207);
    for (int a = 0; a < 16; a++) do_read(a);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        do_write(a, 4'(b), (32'(a) * 32'h9E37_79B1) ^ (32'(b) * 32'h0101_0101) ^ 32'(a * 16 + b));
        do_read(a);
      end
    for (int a = 0; a < 16; a++) do_read(15 - a);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule